// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control sequencer that a small CPU core uses to take and leave interrupts. A request is accepted only at a boundary between instructions, or at once while the core sleeps. The block then holds the core for exactly four cycles. In that time it sends an acknowledge pulse to the winning source, writes the return program counter as two bytes onto a downward-growing stack, and loads the program counter with that source's vector address. The vector address holds a two-cycle relative jump into the service routine, and the core executes that jump itself.

A return strobe from the core starts a four-cycle exit. The block reads the two stacked bytes back in reverse order, reloads the program counter and sets the global enable again. After a return, the interrupted program must complete one more instruction before any pending request can be accepted. The status register is not saved here. Software saves it when a routine needs it. The block also owns the stack pointer register.

Top module: `irq_sequencer`

## Requirements
- R1: While reset is high and directly after it, core_hold, pc_load, mem_we and irq_ack are all 0, sp equals SP_INIT (0xFF by default) and gie equals GIE_INIT (1 by default).
- R2: A request is accepted only in the idle state with gie set, and only with insn_done or sleeping high in the same cycle. A request with both of those low is not taken.
- R3: Among simultaneous requests the lowest index wins. In the first entry cycle irq_ack carries a one-hot pulse at that index for exactly one cycle, and irq_ack is zero otherwise.
- R4: In entry cycle 1, mem_wdata holds PC bits [7:0] and is written at address sp. In entry cycle 2, PC bits [PCW-1:8] zero-extended are written at sp-1. After entry, sp is 2 lower than before.
- R5: core_hold is high for the four entry cycles. In the fourth, pc_load pulses with pc_value = VEC_BASE + index*VEC_STEP.
- R6: gie is cleared on acceptance, and requests with a boundary strobe are ignored while it is clear.
- R7: A reti strobe in the idle state starts a four-cycle return. The block reads the high byte at sp+1 and then the low byte at sp+2, and sp rises by 2. In the fourth cycle pc_load pulses with the restored PC, and after that gie is 1.
- R8: After a return, the next insn_done only ends the one-instruction gap and accepts no request. A later boundary can accept one.
- R9: While sleeping is high, a pending request is accepted without insn_done, and the stacked return address is pc_in as sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | Pending request flags, index 0 highest priority |
| irq_ack | output | NSRC | One-hot acknowledge pulse in the first entry cycle |
| gie | output | 1 | Global interrupt enable |
| insn_done | input | 1 | Current instruction completes this cycle |
| sleeping | input | 1 | Core is in a sleep state |
| reti | input | 1 | Return-from-interrupt strobe |
| core_hold | output | 1 | Stalls the core during entry and return |
| pc_in | input | PCW | Address of the next instruction to execute |
| pc_load | output | 1 | Load pc_value into the program counter |
| pc_value | output | PCW | Vector or restored address |
| sp | output | SPW | Stack pointer |
| mem_we | output | 1 | Stack byte write enable |
| mem_addr | output | SPW | Stack byte address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, combinational from mem_addr |

## Verification
An acceptance or reti strobe is sampled on one rising edge. The first sequence cycle appears right after that edge: the acknowledge pulse, the low-byte write or the high-byte read. Each later step follows one edge after the previous one, and pc_load comes three edges after the first cycle. The bench drives inputs and samples outputs on falling edges, advancing exactly one edge per step, so every check lands on the cycle its result is due. The stack pointer is checked on the cycle after each sequence ends. Refusals are checked one edge after the refused stimulus, by observing core_hold and irq_ack.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENT0,
        ST_ENT1,
        ST_ENT2,
        ST_ENT3,
        ST_RET0,
        ST_RET1,
        ST_RET2,
        ST_RET3,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_PUSH,
        SP_POP
    } sp_op_t;

    function automatic logic is_entry(input seq_state_t s);
        return (s == ST_ENT0) || (s == ST_ENT1) || (s == ST_ENT2) || (s == ST_ENT3);
    endfunction

    function automatic logic is_return(input seq_state_t s);
        return (s == ST_RET0) || (s == ST_RET1) || (s == ST_RET2) || (s == ST_RET3);
    endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC = 4,
    parameter int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req,
    output logic            valid,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
    end

    assign valid = |req;

    // Lowest set index wins (R3)
    always_comb begin
        if (valid) assert_pick_is_set_R3: assert (req[idx]);
    end
endmodule

// File: rtl/irq_stack_port.sv
module irq_stack_port
    import irq_seq_pkg::*;
#(
    parameter int          SPW     = 8,
    parameter logic [SPW-1:0] SP_INIT = '1
) (
    input  logic           clk,
    input  logic           rst,
    input  sp_op_t         op,
    input  logic [7:0]     wbyte,
    output logic [SPW-1:0] sp,
    output logic [SPW-1:0] mem_addr,
    output logic           mem_we,
    output logic [7:0]     mem_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_INIT;
        end else begin
            case (op)
                SP_PUSH: sp <= sp - SPW'(1);
                SP_POP:  sp <= sp + SPW'(1);
                default: sp <= sp;
            endcase
        end
    end

    assign mem_we    = (op == SP_PUSH);
    assign mem_addr  = (op == SP_POP) ? sp + SPW'(1) : sp;
    assign mem_wdata = wbyte;

    assert_push_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (op == SP_PUSH) |=> (sp == $past(sp) - SPW'(1)));
    assert_pop_inc_R7: assert property (@(posedge clk) disable iff (rst)
        (op == SP_POP) |=> (sp == $past(sp) + SPW'(1)));
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int          NSRC     = 4,
    parameter int          PCW      = 12,
    parameter int          SPW      = 8,
    parameter logic [SPW-1:0] SP_INIT = '1,
    parameter int          VEC_BASE = 1,
    parameter int          VEC_STEP = 2,
    parameter bit          GIE_INIT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] irq_req,
    output logic [NSRC-1:0] irq_ack,
    output logic            gie,
    input  logic            insn_done,
    input  logic            sleeping,
    input  logic            reti,
    output logic            core_hold,
    input  logic [PCW-1:0]  pc_in,
    output logic            pc_load,
    output logic [PCW-1:0]  pc_value,
    output logic [SPW-1:0]  sp,
    output logic            mem_we,
    output logic [SPW-1:0]  mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata
);
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    seq_state_t      state;
    logic [PCW-1:0]  ret_pc;
    logic [IDXW-1:0] src_idx;
    logic [7:0]      pc_hi, pc_lo;
    logic            pick_valid;
    logic [IDXW-1:0] pick_idx;
    logic            accept;
    sp_op_t          sp_op;
    logic [7:0]      push_byte;

    irq_prio_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
        .req   (irq_req),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    assign accept = (state == ST_IDLE) && gie && pick_valid && !reti &&
                    (insn_done || sleeping);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            gie     <= GIE_INIT;
            ret_pc  <= '0;
            src_idx <= '0;
            pc_hi   <= '0;
            pc_lo   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (reti) begin
                        state <= ST_RET0;
                    end else if (accept) begin
                        state   <= ST_ENT0;
                        ret_pc  <= pc_in;
                        src_idx <= pick_idx;
                        gie     <= 1'b0;
                    end
                end
                ST_ENT0: state <= ST_ENT1;
                ST_ENT1: state <= ST_ENT2;
                ST_ENT2: state <= ST_ENT3;
                ST_ENT3: state <= ST_IDLE;
                ST_RET0: begin
                    pc_hi <= mem_rdata;
                    state <= ST_RET1;
                end
                ST_RET1: begin
                    pc_lo <= mem_rdata;
                    state <= ST_RET2;
                end
                ST_RET2: state <= ST_RET3;
                ST_RET3: begin
                    gie   <= 1'b1;
                    state <= ST_GAP;
                end
                ST_GAP: if (insn_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_ENT0, ST_ENT1: sp_op = SP_PUSH;
            ST_RET0, ST_RET1: sp_op = SP_POP;
            default:          sp_op = SP_HOLD;
        endcase
    end

    assign push_byte = (state == ST_ENT1) ? 8'(ret_pc >> 8) : ret_pc[7:0];

    irq_stack_port #(.SPW(SPW), .SP_INIT(SP_INIT)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .op        (sp_op),
        .wbyte     (push_byte),
        .sp        (sp),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_ack
            assign irq_ack[g] = (state == ST_ENT0) && (src_idx == IDXW'(g));
        end
    endgenerate

    assign core_hold = is_entry(state) || is_return(state);
    assign pc_load   = (state == ST_ENT3) || (state == ST_RET3);
    assign pc_value  = (state == ST_ENT3)
                     ? PCW'(VEC_BASE) + PCW'(src_idx) * PCW'(VEC_STEP)
                     : PCW'({pc_hi, pc_lo});

    assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));
    assert_ack_single_R3: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |=> (irq_ack == '0));
    assert_entry_sp_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ENT3) |-> (sp == $past(sp, 3) - SPW'(2)));
    assert_vector_load_R5: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |-> ##3 (pc_load && core_hold));
    assert_gie_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |-> !gie);
    assert_ret_restore_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RET3) |=> (gie && !core_hold && !pc_load));
    assert_gap_no_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |=> !core_hold);
endmodule

// File: tb/test_irq_sequencer.sv
module test_irq_sequencer;
    localparam int NSRC = 4;
    localparam int PCW  = 12;
    localparam int SPW  = 8;
    localparam int VB   = 1;
    localparam int VS   = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] irq_req = '0;
    logic [NSRC-1:0] irq_ack;
    logic            gie;
    logic            insn_done = 1'b0;
    logic            sleeping = 1'b0;
    logic            reti = 1'b0;
    logic            core_hold;
    logic [PCW-1:0]  pc_in = '0;
    logic            pc_load;
    logic [PCW-1:0]  pc_value;
    logic [SPW-1:0]  sp;
    logic            mem_we;
    logic [SPW-1:0]  mem_addr;
    logic [7:0]      mem_wdata;
    logic [7:0]      mem_rdata;

    logic [7:0] stk [0:255];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [SPW-1:0] exp_sp;

    always #5 clk = ~clk;

    irq_sequencer #(.NSRC(NSRC), .PCW(PCW), .SPW(SPW), .VEC_BASE(VB), .VEC_STEP(VS))
    i_irq_sequencer (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack), .gie(gie),
        .insn_done(insn_done), .sleeping(sleeping), .reti(reti), .core_hold(core_hold),
        .pc_in(pc_in), .pc_load(pc_load), .pc_value(pc_value), .sp(sp),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) if (mem_we) stk[mem_addr] <= mem_wdata;
    assign mem_rdata = stk[mem_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_entry(input logic [NSRC-1:0] pat, input logic [PCW-1:0] pc,
                            input bit use_sleep);
        int idx = 0;
        for (int i = NSRC - 1; i >= 0; i--) if (pat[i]) idx = i;
        // R2: no boundary, not sleeping -> refused
        @(negedge clk); irq_req = pat; pc_in = pc; insn_done = 0; sleeping = 0;
        @(negedge clk);
        chk(!core_hold && irq_ack == 0, "R2 refused", int'(core_hold), 0);
        insn_done = !use_sleep; sleeping = use_sleep;
        @(negedge clk); // first entry cycle
        insn_done = 0; sleeping = 0; irq_req = '0; pc_in = '0;
        chk(irq_ack == NSRC'(1 << idx), "R3 ack", int'(irq_ack), 1 << idx);
        chk(mem_we && mem_addr == exp_sp && mem_wdata == pc[7:0],
            use_sleep ? "R9 low byte" : "R4 low byte", int'(mem_wdata), int'(pc[7:0]));
        chk(!gie, "R6 gie cleared", int'(gie), 0);
        chk(core_hold, "R5 hold", int'(core_hold), 1);
        @(negedge clk);
        chk(irq_ack == 0, "R3 single pulse", int'(irq_ack), 0);
        chk(mem_we && mem_addr == exp_sp - 8'd1 && mem_wdata == 8'(pc >> 8),
            "R4 high byte", int'(mem_wdata), int'(pc >> 8));
        @(negedge clk);
        chk(core_hold && !mem_we && !pc_load, "R5 third cycle", int'(pc_load), 0);
        @(negedge clk);
        chk(pc_load && pc_value == PCW'(VB + idx * VS), "R5 vector",
            int'(pc_value), VB + idx * VS);
        @(negedge clk);
        chk(!core_hold && sp == exp_sp - 8'd2, "R4 sp after entry", int'(sp),
            int'(exp_sp - 8'd2));
        exp_sp = exp_sp - 8'd2;
        // R6: requests ignored while gie clear
        irq_req = pat; insn_done = 1;
        @(negedge clk);
        chk(!core_hold && irq_ack == 0, "R6 ignored", int'(irq_ack), 0);
        irq_req = '0; insn_done = 0;
    endtask

    task automatic do_return(input logic [PCW-1:0] pc);
        reti = 1;
        @(negedge clk);
        reti = 0;
        chk(core_hold && mem_addr == exp_sp + 8'd1, "R7 high addr", int'(mem_addr),
            int'(exp_sp + 8'd1));
        @(negedge clk);
        chk(mem_addr == exp_sp + 8'd2, "R7 low addr", int'(mem_addr), int'(exp_sp + 8'd2));
        @(negedge clk);
        @(negedge clk);
        chk(pc_load && pc_value == pc, "R7 restored pc", int'(pc_value), int'(pc));
        @(negedge clk);
        exp_sp = exp_sp + 8'd2;
        chk(gie && !core_hold && sp == exp_sp, "R7 gie and sp", int'(sp), int'(exp_sp));
        // R8: first boundary only closes the gap
        irq_req = 4'b0001; insn_done = 1;
        @(negedge clk);
        chk(!core_hold && irq_ack == 0, "R8 gap", int'(irq_ack), 0);
        irq_req = '0; insn_done = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        exp_sp = 8'hFF;
        @(negedge clk); @(negedge clk);
        chk(!core_hold && !pc_load && !mem_we && irq_ack == 0 && sp == 8'hFF && gie,
            "R1 reset", int'(sp), 8'hFF);
        rst = 0;
        @(negedge clk);
        chk(!core_hold && sp == 8'hFF && gie, "R1 after reset", int'(sp), 8'hFF);
        for (int p = 1; p < 16; p++) begin
            logic [PCW-1:0] pc = PCW'(p * 12'h1A7 + 12'h035);
            do_entry(NSRC'(p), pc, p[0]);
            do_return(pc);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule